// File: doc/BRIEF.md
# Single-Wire Bus Device Bit Responder

This block is the bit layer of a device on a single-wire open-drain bus. It reads the bus level through an input that has already been synchronized, and it pulls the bus low through a registered enable. A wired-AND pull-up outside the block forms the bus level from that enable and the master's drive. The block tells bus resets apart from data slots by how long the line stays low. It answers each reset with a presence pulse that is timed from the moment the line returns high.

For data, every falling edge that the master makes starts an internal timer. In a write slot the block samples the line once, at a fixed point, and reports the bit with a one-cycle strobe. In a read slot it looks at the bit to send. It returns a zero by holding the line low past the master's own short pulse, and it returns a one by leaving the line alone. A layer above the block decides, before each slot begins, whether the slot is a read and which bit to send. All times are counted in clock cycles and set by parameters.

Top module: `owr_bit_responder`

## Requirements
- R1: After reset, `pull_low`, `rx_valid` and `bus_reset` are all 0.
- R2: A low that lasts at least RST_MIN clock samples raises `bus_reset` for exactly one cycle. The strobe is visible after the RST_MIN-th low sample. A low of RST_MIN-1 samples raises no strobe.
- R3: After a reset, call the first high sample of the line h. `pull_low` rises on the edge at h+PD_HIGH and stays high for exactly PD_LOW cycles.
- R4: In a write slot whose first low sample is k, `rx_valid` pulses for exactly one cycle, on the edge at k+SAMPLE_AT. `rx_bit` is the line level at that edge. A master low of at most SAMPLE_AT samples therefore gives 1, and a longer low gives 0.
- R5: In a read slot with `tx_bit`=0, `pull_low` rises on the edge at k and falls on the edge at k+READ_HOLD. A read slot never pulses `rx_valid`.
- R6: In a read slot with `tx_bit`=1, `pull_low` stays 0 for the whole slot.
- R7: The line is taken as high again at an edge r once the timer has reached max(SAMPLE_AT,READ_HOLD)+1. A falling edge that arrives before REC_T further high samples have passed after r starts no slot.
- R8: A falling edge caused by the block's own pull-down (the presence pulse) starts no slot and gives no `rx_valid`.
- R9: A reset-length low that begins as a slot aborts that slot. `pull_low` is then 0 until the presence pulse, and the presence sequence of R3 follows.
- R10: `tx_bit` and `tx_is_read` are sampled at the falling edge that opens the slot. Their values at any other time have no effect on that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Synchronized bus level (1 = high) |
| tx_bit | input | 1 | Bit to return in the next read slot |
| tx_is_read | input | 1 | 1: the next slot is a read slot; 0: it is a write slot |
| pull_low | output | 1 | Open-drain enable; 1 drives the bus low |
| rx_valid | output | 1 | One-cycle strobe for a received write bit |
| rx_bit | output | 1 | Received bit, valid with `rx_valid` |
| bus_reset | output | 1 | One-cycle strobe when a bus reset is detected |

## Verification
Every result is timed from the first clock edge that sees the line low. Call that edge k.
- The write strobe is due one cycle after edge k+SAMPLE_AT.
- A read-zero pull-down is seen from just after edge k until just after edge k+READ_HOLD.
- The reset strobe is due after the RST_MIN-th low sample.
- The presence pulse is due PD_HIGH cycles after the first high sample, and it lasts PD_LOW cycles.

The bench drives the master level on falling clock edges and counts falling edges from the start of each pulse. At the j-th falling edge it compares the outputs with the values due after rising edge k+j-1, so each check lands on the exact cycle worked out from the requirement.

// File: rtl/owr_pkg.sv
package owr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_REC,
    ST_RWAIT,
    ST_PDLY,
    ST_PLOW
  } owr_state_e;

  // Timer value at which a slot may be closed by a high line.
  function automatic int unsigned slot_close_at(int unsigned samp, int unsigned hold);
    return ((samp > hold) ? samp : hold) + 1;
  endfunction

  // Bit a write slot carries for a given master low length (in samples).
  function automatic logic write_value(int unsigned low_len, int unsigned samp);
    return (low_len <= samp) ? 1'b1 : 1'b0;
  endfunction

  // Whether a read slot needs the pull-down for the given bit.
  function automatic logic read_needs_pull(logic is_read, logic bit_val);
    return is_read & ~bit_val;
  endfunction

endpackage

// File: rtl/owr_line_mon.sv
module owr_line_mon #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_MIN = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic pull_low,
  output logic fall_ev,
  output logic rst_hit,
  output logic bus_reset
);

  localparam logic [CNT_W-1:0] K_RST  = CNT_W'(RST_MIN);
  localparam logic [CNT_W-1:0] K_HIT  = CNT_W'(RST_MIN - 1);

  logic             line_q;
  logic [CNT_W-1:0] low_cnt;

  // Falling edge made by the master only: the block's own pull is masked.
  assign fall_ev = line_q & ~line_in & ~pull_low;
  assign rst_hit = ~line_in & (low_cnt == K_HIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q    <= 1'b1;
      low_cnt   <= '0;
      bus_reset <= 1'b0;
    end else begin
      line_q    <= line_in;
      bus_reset <= rst_hit;
      if (line_in)
        low_cnt <= '0;
      else if (low_cnt != K_RST)
        low_cnt <= low_cnt + 1'b1;
    end
  end

  // R2: a reset hit needs the line low now and on the previous sample
  p_hit_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |-> (!line_in && $past(!line_in)));

  // R2: the reset strobe is a single cycle
  p_reset_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !bus_reset);

  // R8: an edge is never reported while the block itself pulls the line
  p_own_edge_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_low && $past(pull_low)) |-> !fall_ev);

endmodule

// File: rtl/owr_seq.sv
module owr_seq
  import owr_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PD_HIGH   = 4,
  parameter int unsigned PD_LOW    = 16,
  parameter int unsigned SAMPLE_AT = 6,
  parameter int unsigned READ_HOLD = 10,
  parameter int unsigned REC_T     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic fall_ev,
  input  logic rst_hit,
  input  logic tx_bit,
  input  logic tx_is_read,
  output logic pull_low,
  output logic rx_valid,
  output logic rx_bit
);

  localparam int unsigned    CLOSE_AT = slot_close_at(SAMPLE_AT, READ_HOLD);
  localparam logic [CNT_W-1:0] K_SAMP  = CNT_W'(SAMPLE_AT);
  localparam logic [CNT_W-1:0] K_HOLD  = CNT_W'(READ_HOLD);
  localparam logic [CNT_W-1:0] K_CLOSE = CNT_W'(CLOSE_AT);
  localparam logic [CNT_W-1:0] K_REC   = CNT_W'(REC_T);
  localparam logic [CNT_W-1:0] K_PDH   = CNT_W'(PD_HIGH);
  localparam logic [CNT_W-1:0] K_PDL   = CNT_W'(PD_LOW);

  owr_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             slot_rd;
  logic             slot_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      slot_rd  <= 1'b0;
      slot_b   <= 1'b1;
      pull_low <= 1'b0;
      rx_valid <= 1'b0;
      rx_bit   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rst_hit) begin
        state    <= ST_RWAIT;
        cnt      <= '0;
        pull_low <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (fall_ev) begin
              state    <= ST_SLOT;
              cnt      <= CNT_W'(1);
              slot_rd  <= tx_is_read;
              slot_b   <= tx_bit;
              pull_low <= read_needs_pull(tx_is_read, tx_bit);
            end
          end
          ST_SLOT: begin
            if (cnt < K_CLOSE) cnt <= cnt + 1'b1;
            if (!slot_rd && cnt == K_SAMP) begin
              rx_valid <= 1'b1;
              rx_bit   <= line_in;
            end
            if (pull_low && cnt == K_HOLD) pull_low <= 1'b0;
            if (cnt >= K_CLOSE && line_in) begin
              state <= ST_REC;
              cnt   <= CNT_W'(1);
            end
          end
          ST_REC: begin
            if (!line_in)
              cnt <= '0;
            else if (cnt >= K_REC)
              state <= ST_IDLE;
            else
              cnt <= cnt + 1'b1;
          end
          ST_RWAIT: begin
            if (line_in) begin
              state <= ST_PDLY;
              cnt   <= CNT_W'(1);
            end
          end
          ST_PDLY: begin
            if (cnt == K_PDH) begin
              pull_low <= 1'b1;
              state    <= ST_PLOW;
              cnt      <= CNT_W'(1);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PLOW: begin
            if (cnt == K_PDL) begin
              pull_low <= 1'b0;
              state    <= ST_REC;
              cnt      <= CNT_W'(1);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R4: the write strobe lasts one cycle
  p_rx_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5: read slots never produce a received bit
  p_no_rx_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !slot_rd);

  // R6: a read slot returning one leaves the line alone
  p_read_one_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLOT && slot_rd && slot_b) |-> !pull_low);

  // R5/R3: the pull starts only at a master edge or at the end of the presence delay
  p_pull_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_low) |-> ($past(fall_ev) || $past(state) == ST_PDLY));

  // R9: a reset releases the line on the next cycle
  p_reset_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> !pull_low);

  // R7: an edge during recovery opens no slot
  p_rec_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REC && fall_ev && !rst_hit) |=> state != ST_SLOT);

  // R8: the presence pulse leads only to its own end or to recovery
  p_presence_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PLOW && !rst_hit) |=> (state == ST_PLOW || state == ST_REC));

endmodule

// File: rtl/owr_bit_responder.sv
module owr_bit_responder #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned RST_MIN   = 48,
  parameter int unsigned PD_HIGH   = 4,
  parameter int unsigned PD_LOW    = 16,
  parameter int unsigned SAMPLE_AT = 6,
  parameter int unsigned READ_HOLD = 10,
  parameter int unsigned REC_T     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic tx_bit,
  input  logic tx_is_read,
  output logic pull_low,
  output logic rx_valid,
  output logic rx_bit,
  output logic bus_reset
);

  logic fall_ev;
  logic rst_hit;

  owr_line_mon #(
    .CNT_W   (CNT_W),
    .RST_MIN (RST_MIN)
  ) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .pull_low  (pull_low),
    .fall_ev   (fall_ev),
    .rst_hit   (rst_hit),
    .bus_reset (bus_reset)
  );

  owr_seq #(
    .CNT_W     (CNT_W),
    .PD_HIGH   (PD_HIGH),
    .PD_LOW    (PD_LOW),
    .SAMPLE_AT (SAMPLE_AT),
    .READ_HOLD (READ_HOLD),
    .REC_T     (REC_T)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .fall_ev    (fall_ev),
    .rst_hit    (rst_hit),
    .tx_bit     (tx_bit),
    .tx_is_read (tx_is_read),
    .pull_low   (pull_low),
    .rx_valid   (rx_valid),
    .rx_bit     (rx_bit)
  );

  // R1: outputs are quiet in the cycle after reset is released
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    (!rst_n) |=> (!pull_low && !rx_valid && !bus_reset));

endmodule

// File: tb/tb_owr_bit_responder.sv
module tb_owr_bit_responder;

  localparam int CLK_PERIOD = 10;
  localparam int RST_MIN    = 48;
  localparam int PDH        = 4;
  localparam int PDL        = 16;
  localparam int SAMP       = 6;
  localparam int HOLD       = 10;
  localparam int RECT       = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic tx_bit = 1'b1;
  logic tx_is_read = 1'b0;
  logic pull_low, rx_valid, rx_bit, bus_reset;
  wire  line_in = ~(m_low | pull_low);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  owr_bit_responder #(
    .CNT_W(8), .RST_MIN(RST_MIN), .PD_HIGH(PDH), .PD_LOW(PDL),
    .SAMPLE_AT(SAMP), .READ_HOLD(HOLD), .REC_T(RECT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .tx_bit(tx_bit),
    .tx_is_read(tx_is_read), .pull_low(pull_low), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .bus_reset(bus_reset)
  );

  function automatic bit exp_wbit(int len);
    return (len <= SAMP);
  endfunction

  function automatic bit exp_read_pull(bit b, int j);
    return (!b && j <= HOLD);
  endfunction

  function automatic bit exp_presence(int i);
    return (i >= PDH + 1 && i <= PDH + PDL);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One slot: master low for len samples, the slot read or write.
  task automatic do_slot(int len, bit rd, bit b);
    int tot;
    bit exp_rx;
    tot = (len > HOLD + 2) ? len : HOLD + 2;
    @(negedge clk);
    tx_is_read = rd;
    tx_bit     = b;
    m_low      = 1'b1;
    for (int j = 1; j <= tot; j++) begin
      @(negedge clk);
      // R10: change the slot inputs after the edge; they must not matter
      tx_is_read = ~rd;
      tx_bit     = ~b;
      exp_rx = (!rd && j == SAMP + 1);
      chk(rx_valid == exp_rx, rd ? "R5 rx_valid in read slot" : "R4 rx_valid timing",
          rx_valid, exp_rx);
      if (rx_valid && exp_rx)
        chk(rx_bit == exp_wbit(len), "R4 rx_bit value", rx_bit, exp_wbit(len));
      if (rd)
        chk(pull_low == exp_read_pull(b, j), b ? "R6 read-one pull" : "R5 read-zero pull",
            pull_low, exp_read_pull(b, j));
      else
        chk(pull_low == 1'b0, "R10 write slot pull", pull_low, 0);
      chk(bus_reset == 1'b0, "R2 no reset on short low", bus_reset, 0);
      if (j == len) m_low = 1'b0;
    end
    idle(20 + int'($urandom % 6));
  endtask

  // Reset-length low, optionally opened as a read-zero slot.
  task automatic do_reset(int len, bit rd0);
    @(negedge clk);
    tx_is_read = rd0;
    tx_bit     = 1'b0;
    m_low      = 1'b1;
    for (int j = 1; j <= len; j++) begin
      @(negedge clk);
      chk(bus_reset == (j == RST_MIN), "R2 reset strobe", bus_reset, (j == RST_MIN));
      if (rd0 && j <= HOLD)
        chk(pull_low == 1'b1, "R9 read pull before reset", pull_low, 1);
      if (j > HOLD)
        chk(pull_low == 1'b0, "R9 released during reset", pull_low, 0);
      if (j == len) m_low = 1'b0;
    end
    tx_is_read = 1'b0;
    tx_bit     = 1'b1;
    for (int i = 1; i <= PDH + PDL + 20; i++) begin
      @(negedge clk);
      chk(pull_low == exp_presence(i), "R3 presence pulse", pull_low, exp_presence(i));
      chk(rx_valid == 1'b0, "R8 no rx from own edge", rx_valid, 0);
      chk(bus_reset == 1'b0, "R2 single reset strobe", bus_reset, 0);
    end
    idle(10);
  endtask

  // Second falling edge inside the recovery window is ignored.
  task automatic do_recovery_probe();
    bit exp_rx;
    @(negedge clk);
    tx_is_read = 1'b0;
    m_low      = 1'b1;
    for (int j = 1; j <= 36; j++) begin
      @(negedge clk);
      exp_rx = (j == SAMP + 1);
      chk(rx_valid == exp_rx, "R7 edge in recovery ignored", rx_valid, exp_rx);
      if (j == 2)  m_low = 1'b0;
      if (j == 12) m_low = 1'b1;
      if (j == 14) m_low = 1'b0;
    end
    idle(20);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle(4);
    chk(pull_low == 1'b0,  "R1 pull_low at reset",  pull_low, 0);
    chk(rx_valid == 1'b0,  "R1 rx_valid at reset",  rx_valid, 0);
    chk(bus_reset == 1'b0, "R1 bus_reset at reset", bus_reset, 0);
    rst_n = 1'b1;
    idle(3);
    chk(pull_low == 1'b0, "R1 pull_low after reset", pull_low, 0);

    // directed boundaries
    do_slot(SAMP, 1'b0, 1'b0);          // R4 longest one
    do_slot(SAMP + 1, 1'b0, 1'b0);      // R4 shortest zero
    do_slot(1, 1'b0, 1'b0);             // R4 minimal low
    do_slot(RST_MIN - 1, 1'b0, 1'b0);   // R2 just short of reset
    do_slot(2, 1'b1, 1'b0);             // R5 read zero
    do_slot(2, 1'b1, 1'b1);             // R6 read one
    do_reset(RST_MIN, 1'b0);            // R2, R3 exact length
    do_reset(RST_MIN + 7, 1'b1);        // R9 abort a read-zero slot
    do_recovery_probe();                // R7
    do_slot(3, 1'b0, 1'b1);             // back to normal after probe

    // random slots
    for (int n = 0; n < 40; n++) begin
      bit rd, b;
      int len;
      rd = $urandom % 2;
      b  = $urandom % 2;
      if (rd)
        len = 1 + int'($urandom % 3);
      else if (b)
        len = 1 + int'($urandom % SAMP);
      else
        len = SAMP + 1 + int'($urandom % 20);
      do_slot(len, rd, b);
    end
    do_reset(RST_MIN + 3, 1'b0);
    do_slot(4, 1'b0, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule